// File: doc/BRIEF.md
# DDR2 Read/Write Data-Window Generator

This block watches the column commands a controller sends to a DDR2-style memory and works out, cycle by cycle, when data belongs on the bus. For each read it raises a read-data-valid window. For each write it raises a write-data-enable window and a matching data-mask-enable window. Since two beats move per clock, a burst occupies half as many clocks as it has beats.

The read latency is the sum of the additive (posted-column) latency and the CAS latency. The write latency is one clock shorter. Both directions are scheduled by occupancy shift pipelines, one per direction. They are deep enough to hold every command in flight, so bursts issued back to back form one unbroken window.

A mode setting (CAS latency, additive latency, burst size) is loaded through a load strobe. The block rejects and flags a load that arrives while traffic is in flight or that carries an illegal value. It also flags any command whose data window would land on a window already booked in the opposite direction.

Top module: `ddr2_data_window_gen`

## Requirements
- R1: After reset all five outputs are low, and the active mode is CAS latency 3, additive latency 0 and 4-beat bursts.
- R2: A read command sampled at clock edge E drives `rd_window` high in the cycles that follow edges E+AL+CL through E+AL+CL+B-1, where B is the burst length in clocks.
- R3: A write command sampled at edge E drives `wr_window` high in the cycles that follow edges E+AL+CL-1 through E+AL+CL+B-2.
- R4: B is 2 clocks when `cfg_burst8` is 0 (4 beats) and 4 clocks when it is 1 (8 beats).
- R5: `dm_window` is high in exactly the cycles in which `wr_window` is high, and a read alone never raises it.
- R6: Same-direction commands issued exactly B cycles apart produce windows that meet with no idle cycle between them.
- R7: A load (`cfg_load` high at an edge) takes effect for commands from the next edge onward. It is accepted only if CAS latency is 3, 4 or 5, additive latency is 0 to 4, no window is pending and no command is presented in the same cycle.
- R8: A load rejected because traffic is pending leaves the mode unchanged and raises `cfg_err` for exactly the cycle after that edge.
- R9: A load with an out-of-range CAS or additive latency is rejected in the same way: `cfg_err` pulses and the mode is unchanged.
- R10: A command whose window would share any cycle with a pending window of the opposite direction raises `turn_conflict` for the single cycle after its edge. The command is still scheduled. Windows that only touch end to end do not raise the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A column command is presented this cycle |
| cmd_is_write | input | 1 | 1 marks the command as a write, 0 as a read |
| cfg_load | input | 1 | Request to load the mode fields below |
| cfg_cas_lat | input | 3 | CAS latency in clocks (3 to 5) |
| cfg_add_lat | input | 3 | Additive latency in clocks (0 to 4) |
| cfg_burst8 | input | 1 | 1 selects 8-beat bursts, 0 selects 4-beat bursts |
| rd_window | output | 1 | Read data is due on the bus this cycle |
| wr_window | output | 1 | Write data is due on the bus this cycle |
| dm_window | output | 1 | Write data mask is due on the bus this cycle |
| cfg_err | output | 1 | One-cycle pulse: the previous load was rejected |
| turn_conflict | output | 1 | One-cycle pulse: the previous command collides with the opposite direction |

## Verification
The assertions assume at most one command per cycle and a latency sum that keeps the inserted window at least two pipeline positions from the output. The guarded mode register enforces that sum, so the assumption holds for any input sequence. The stimulus changes the mode only through the load strobe and drives every input half a clock away from the sampling edge. It issues commands only after the reset synchronizer has released, so no command meets a partly reset pipeline. Illegal mode values and loads under traffic are applied on purpose, because the mode guard must hold even then.

// File: rtl/ddr2_win_pkg.sv
package ddr2_win_pkg;
  localparam int CL_MIN    = 3;
  localparam int CL_MAX    = 5;
  localparam int AL_MAX    = 4;
  localparam int BEATS_MAX = 8;
  localparam int BEATS_MIN = 4;
  localparam int LAT_MAX   = AL_MAX + CL_MAX;
  localparam int DEPTH     = LAT_MAX + BEATS_MAX / 2;
  localparam int LAT_W     = $clog2(DEPTH + 1);
  localparam int FLD_W     = 3;

  typedef logic [DEPTH-1:0] occ_t;

  typedef struct packed {
    logic [FLD_W-1:0] cl;
    logic [FLD_W-1:0] al;
    logic             bl8;
  } mode_t;

  // Bits [lat, lat+nclk) set: cycles a burst occupies, counted from the edge after insertion.
  function automatic occ_t span_mask(input logic [LAT_W-1:0] lat, input logic [LAT_W-1:0] nclk);
    occ_t m;
    for (int i = 0; i < DEPTH; i++) begin
      m[i] = (LAT_W'(i) >= lat) && ((LAT_W+1)'(i) < ((LAT_W+1)'(lat) + (LAT_W+1)'(nclk)));
    end
    return m;
  endfunction
endpackage

// File: rtl/ddr2_win_rst_sync.sv
module ddr2_win_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ddr2_win_cfg.sv
module ddr2_win_cfg
  import ddr2_win_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [FLD_W-1:0] cl_i,
  input  logic [FLD_W-1:0] al_i,
  input  logic             bl8_i,
  input  logic             busy_i,
  output mode_t            mode_o,
  output logic             err_o
);
  mode_t mode_q, mode_d;
  logic  err_q, err_d;
  logic  legal, accept;

  always_comb begin
    legal  = (cl_i >= FLD_W'(CL_MIN)) && (cl_i <= FLD_W'(CL_MAX)) && (al_i <= FLD_W'(AL_MAX));
    accept = load_i && legal && !busy_i;
    mode_d = mode_q;
    if (accept) begin
      mode_d.cl  = cl_i;
      mode_d.al  = al_i;
      mode_d.bl8 = bl8_i;
    end
    err_d = load_i && !accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{cl: FLD_W'(CL_MIN), al: '0, bl8: 1'b0};
      err_q  <= 1'b0;
    end else begin
      if (accept) mode_q <= mode_d;
      err_q <= err_d;
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;

  assert_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.cl >= FLD_W'(CL_MIN)) && (mode_q.cl <= FLD_W'(CL_MAX)) && (mode_q.al <= FLD_W'(AL_MAX)));
  assert_mode_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(mode_q));
  assert_err_has_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(load_i));
endmodule

// File: rtl/ddr2_win_lane.sv
module ddr2_win_lane
  import ddr2_win_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ins_en,
  input  occ_t ins_mask,
  input  occ_t probe_mask,
  output logic win_o,
  output logic busy_o,
  output logic hit_o
);
  occ_t occ_q, occ_d, occ_adv;
  logic occ_en;

  always_comb begin
    occ_adv = occ_q >> 1;
    occ_d   = occ_adv | (ins_en ? ins_mask : '0);
    occ_en  = ins_en || (occ_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (occ_en) occ_q <= occ_d;
  end

  assign win_o  = occ_q[0];
  assign busy_o = |occ_q;
  assign hit_o  = |(occ_adv & probe_mask);

  assert_burst_two_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_o) |=> win_o);
  assert_rise_was_queued_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_o) |-> $past(busy_o));
endmodule

// File: rtl/ddr2_data_window_gen.sv
module ddr2_data_window_gen
  import ddr2_win_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_is_write,
  input  logic             cfg_load,
  input  logic [FLD_W-1:0] cfg_cas_lat,
  input  logic [FLD_W-1:0] cfg_add_lat,
  input  logic             cfg_burst8,
  output logic             rd_window,
  output logic             wr_window,
  output logic             dm_window,
  output logic             cfg_err,
  output logic             turn_conflict
);
  logic             rst_sync_n;
  mode_t            mode;
  logic [LAT_W-1:0] rd_lat, wr_lat, nclk;
  occ_t             rd_span, wr_span;
  logic             rd_ins, wr_ins;
  logic             rd_busy, wr_busy, rd_hit, wr_hit;
  logic             rd_win, wr_win;
  logic             cfg_busy;
  logic             clash_q, clash_d;

  ddr2_win_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    rd_lat  = LAT_W'(mode.al) + LAT_W'(mode.cl);
    wr_lat  = rd_lat - LAT_W'(1);
    nclk    = mode.bl8 ? LAT_W'(BEATS_MAX / 2) : LAT_W'(BEATS_MIN / 2);
    rd_span = span_mask(rd_lat, nclk);
    wr_span = span_mask(wr_lat, nclk);
    rd_ins  = cmd_valid && !cmd_is_write;
    wr_ins  = cmd_valid && cmd_is_write;
    cfg_busy = rd_busy || wr_busy || cmd_valid;
    // A new write is probed against booked reads and vice versa.
    clash_d = (wr_ins && rd_hit) || (rd_ins && wr_hit);
  end

  ddr2_win_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (cfg_load),
    .cl_i   (cfg_cas_lat),
    .al_i   (cfg_add_lat),
    .bl8_i  (cfg_burst8),
    .busy_i (cfg_busy),
    .mode_o (mode),
    .err_o  (cfg_err)
  );

  ddr2_win_lane u_rd_lane (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ins_en     (rd_ins),
    .ins_mask   (rd_span),
    .probe_mask (wr_span),
    .win_o      (rd_win),
    .busy_o     (rd_busy),
    .hit_o      (rd_hit)
  );

  ddr2_win_lane u_wr_lane (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ins_en     (wr_ins),
    .ins_mask   (wr_span),
    .probe_mask (rd_span),
    .win_o      (wr_win),
    .busy_o     (wr_busy),
    .hit_o      (wr_hit)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) clash_q <= 1'b0;
    else             clash_q <= clash_d;
  end

  assign rd_window     = rd_win;
  assign wr_window     = wr_win;
  assign dm_window     = wr_win;
  assign turn_conflict = clash_q;

  assert_clash_has_cmd_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    turn_conflict |-> $past(cmd_valid));
  assert_clash_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    turn_conflict && !cmd_valid |=> !turn_conflict);
  assert_cfg_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_err && !cfg_load |=> !cfg_err);
endmodule

// File: tb/ddr2_data_window_gen_tb.sv
module ddr2_data_window_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_is_write = 1'b0, cfg_load = 1'b0, cfg_burst8 = 1'b0;
  logic [2:0] cfg_cas_lat = 3'd3, cfg_add_lat = 3'd0;
  logic       rd_window, wr_window, dm_window, cfg_err, turn_conflict;

  int  n_chk = 0, n_fail = 0, cyc = 0;
  int  m_cl = 3, m_al = 0, m_bl8 = 0;
  bit  exp_rd [8192];
  bit  exp_wr [8192];
  bit  chk_on = 1'b0;
  string ctx = "R2";

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr2_data_window_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_write(cmd_is_write),
    .cfg_load(cfg_load), .cfg_cas_lat(cfg_cas_lat), .cfg_add_lat(cfg_add_lat),
    .cfg_burst8(cfg_burst8), .rd_window(rd_window), .wr_window(wr_window),
    .dm_window(dm_window), .cfg_err(cfg_err), .turn_conflict(turn_conflict)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  // Per-cycle window comparison against the bench's own schedule (R2, R3, R5).
  always @(negedge clk) begin
    if (chk_on) begin
      chk(rd_window == exp_rd[cyc], {"R2 ", ctx}, "rd_window", rd_window, exp_rd[cyc]);
      chk(wr_window == exp_wr[cyc], {"R3 ", ctx}, "wr_window", wr_window, exp_wr[cyc]);
      chk(dm_window == exp_wr[cyc], {"R5 ", ctx}, "dm_window", dm_window, exp_wr[cyc]);
    end
  end

  function automatic int lat_of(input bit wr);
    return m_al + m_cl - (wr ? 1 : 0);
  endfunction

  function automatic int clk_of();
    return m_bl8 ? 4 : 2;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input bit wr);
    int  e, l, b;
    bit  clash;
    e = cyc + 1;
    l = lat_of(wr);
    b = clk_of();
    clash = 1'b0;
    for (int k = 0; k < b; k++) clash |= wr ? exp_rd[e+l+k] : exp_wr[e+l+k];
    for (int k = 0; k < b; k++) begin
      if (wr) exp_wr[e+l+k] = 1'b1;
      else    exp_rd[e+l+k] = 1'b1;
    end
    cmd_valid = 1'b1;
    cmd_is_write = wr;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(turn_conflict == clash, "R10", "turn_conflict", turn_conflict, clash);
  endtask

  task automatic load_mode(input int cl, input int al, input int bl8, input string tag);
    bit busy, legal, ok;
    busy = 1'b0;
    for (int k = 0; k < 16; k++) busy |= exp_rd[cyc+k] | exp_wr[cyc+k];
    legal = (cl >= 3) && (cl <= 5) && (al <= 4);
    ok = legal && !busy;
    cfg_load = 1'b1;
    cfg_cas_lat = 3'(cl);
    cfg_add_lat = 3'(al);
    cfg_burst8 = bl8[0];
    @(posedge clk);
    @(negedge clk);
    cfg_load = 1'b0;
    chk(cfg_err == !ok, tag, "cfg_err", cfg_err, !ok);
    if (ok) begin
      m_cl = cl; m_al = al; m_bl8 = bl8;
    end
    idle(1);
    chk(cfg_err == 1'b0, tag, "cfg_err second cycle", cfg_err, 0);
  endtask

  task automatic t_reset();
    ctx = "R1";
    chk(rd_window == 0 && wr_window == 0 && dm_window == 0, "R1", "windows after reset",
        {rd_window, wr_window, dm_window}, 0);
    chk(cfg_err == 0 && turn_conflict == 0, "R1", "flags after reset", {cfg_err, turn_conflict}, 0);
    issue(1'b0);
    idle(8);
    issue(1'b1);
    idle(8);
  endtask

  task automatic t_latency_sweep();
    ctx = "R7";
    for (int cl = 3; cl <= 5; cl++) begin
      for (int al = 0; al <= 4; al += 2) begin
        load_mode(cl, al, 0, "R7");
        issue(1'b0);
        idle(14);
        issue(1'b1);
        idle(14);
      end
    end
  endtask

  task automatic t_burst8();
    ctx = "R4";
    load_mode(4, 1, 1, "R4");
    issue(1'b0);
    idle(14);
    issue(1'b1);
    idle(14);
    load_mode(3, 0, 0, "R4");
    issue(1'b0);
    idle(10);
  endtask

  task automatic t_back_to_back();
    ctx = "R6";
    load_mode(5, 2, 0, "R6");
    issue(1'b0); idle(1); issue(1'b0); idle(1); issue(1'b0);
    idle(16);
    issue(1'b1); idle(1); issue(1'b1);
    idle(16);
    load_mode(3, 1, 1, "R6");
    issue(1'b0); idle(3); issue(1'b0);
    idle(16);
  endtask

  task automatic t_cfg_busy();
    ctx = "R8";
    load_mode(3, 0, 0, "R8");
    issue(1'b0);
    load_mode(5, 4, 1, "R8");
    idle(14);
    issue(1'b0);
    idle(10);
  endtask

  task automatic t_cfg_illegal();
    ctx = "R9";
    load_mode(6, 0, 0, "R9");
    load_mode(2, 1, 0, "R9");
    load_mode(4, 5, 1, "R9");
    issue(1'b1);
    idle(10);
  endtask

  task automatic t_conflict();
    ctx = "R10";
    load_mode(3, 0, 0, "R10");
    issue(1'b0); issue(1'b1);
    idle(12);
    issue(1'b1); issue(1'b0);
    idle(12);
    load_mode(4, 2, 1, "R10");
    issue(1'b0); idle(2); issue(1'b1);
    idle(16);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    chk_on = 1'b1;
    t_reset();
    t_latency_sweep();
    t_burst8();
    t_back_to_back();
    t_cfg_busy();
    t_cfg_illegal();
    t_conflict();
    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule